// File: doc/BRIEF.md
# Reloadable Cycle-Count Interrupt Timer

This block counts CPU clock cycles downward from a programmed start value and raises an interrupt request when the count runs out. Software sets the delay through an 8-bit latch. A control register starts and stops counting and masks the request line. A write to the acknowledge register drops the request and starts a new delay. The counter steps once per clock, and each latch unit stands for a 16-cycle step. The longest delay is a little over four thousand cycles.

Two reload formulas apply. Stopping the timer through the control register loads (L+2)*16, or 17 when L is zero. An acknowledge loads (L+1)*16, or 1 when L is zero. Counting needs both the run bit and a separate arm bit in the control word. When the count reaches zero the timer keeps a pending flag and holds the counter at zero. The request line therefore follows the interrupt-enable bit for as long as the flag stays set. Clearing and then setting that bit gives the CPU a fresh edge without an acknowledge.

Top module: `irq_delay_timer`

## Requirements
- R1: After reset the request line is low, counting is off and the counter holds zero. A control write of 0x07 made straight after reset therefore raises the request on the first counting cycle.
- R2: While counting is on, an acknowledge write loads (L+1)*16, or 1 for L=0. The request rises exactly that many clock edges after the edge that captured the write. The counter drops by one on each counting edge.
- R3: A control write with bit 0 clear stops counting and loads (L+2)*16, or 17 for L=0. Once counting is re-enabled, the request rises exactly that many edges after the enabling write.
- R4: The counter moves only while control bit 0 (run) and bit 2 (arm) are both 1. With arm clear the count is held, and a later enable resumes from the held value.
- R5: The request line is high only while the pending flag and control bit 1 (interrupt enable) are both set. A pending flag raised while bit 1 is clear is kept.
- R6: An acknowledge write clears the pending flag, so the request is low after the edge that captured it.
- R7: On reaching zero while counting, the timer sets the pending flag and the counter stays at zero. Clearing bit 1 and then setting it again drops the request and then raises it again.
- R8: A latch write changes no count already in progress. It takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock, one count per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| latch_we_i | input | 1 | Write strobe for the reload latch |
| ctrl_we_i | input | 1 | Write strobe for the control word (bit0 run, bit1 irq enable, bit2 arm) |
| ack_we_i | input | 1 | Write strobe for acknowledge-and-reload |
| wdata_i | input | 8 | Write data bus |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the timer with its default widths: an 8-bit latch, a 16x step and a 13-bit counter. With these values the extreme latch settings can be reached within the run time: L=0 gives the special 1- and 17-cycle reloads, and L=255 gives the longest delays of 4096 and 4112 cycles. The bench measures the exact edge on which the request rises for both reload paths at L=0, small values and 255. It also holds the count with arm clear, stops the count through a control write, and changes the latch during a countdown.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int RUN_BIT   = 0;
  localparam int IRQEN_BIT = 1;
  localparam int ARM_BIT   = 2;

  typedef struct packed {
    logic arm;
    logic irq_en;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] latch_o,
  output tmr_ctrl_t         ctrl_o
);
  logic [DATA_W-1:0] latch_q, latch_d;
  tmr_ctrl_t         ctrl_q, ctrl_d;

  always_comb begin
    latch_d       = wdata_i;
    ctrl_d.run    = wdata_i[RUN_BIT];
    ctrl_d.irq_en = wdata_i[IRQEN_BIT];
    ctrl_d.arm    = wdata_i[ARM_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (latch_we_i) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign latch_o = latch_q;
  assign ctrl_o  = ctrl_q;

  // R8: the latch changes only on its own strobe
  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_q));
endmodule

// File: rtl/irq_timer_reload.sv
module irq_timer_reload #(
  parameter int DATA_W    = 8,
  parameter int PRE_LOG2  = 4,
  parameter int CNT_W     = DATA_W + 1 + PRE_LOG2,
  parameter int ZERO_STOP = 17,
  parameter int ZERO_ACK  = 1
) (
  input  logic [DATA_W-1:0] latch_i,
  output logic [CNT_W-1:0]  stop_val_o,
  output logic [CNT_W-1:0]  ack_val_o
);
  localparam logic [CNT_W-1:0] STOP_Z = CNT_W'(ZERO_STOP);
  localparam logic [CNT_W-1:0] ACK_Z  = CNT_W'(ZERO_ACK);

  logic [CNT_W-1:0] l_ext;
  logic             l_zero;

  always_comb begin
    l_ext      = CNT_W'(latch_i);
    l_zero     = (latch_i == '0);
    stop_val_o = l_zero ? STOP_Z : ((l_ext + CNT_W'(2)) << PRE_LOG2);
    ack_val_o  = l_zero ? ACK_Z  : ((l_ext + CNT_W'(1)) << PRE_LOG2);
  end

  // R3: the stop reload always exceeds the acknowledge reload
  always_comb begin
    assert_stop_gt_ack_R3: assert (stop_val_o > ack_val_o);
  end
endmodule

// File: rtl/irq_timer_counter.sv
module irq_timer_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             cnt_en, pend_en;
  logic             at_end;

  always_comb begin
    at_end  = (cnt_q <= CNT_W'(1));
    cnt_en  = load_i | (count_i & (cnt_q != '0));
    cnt_d   = load_i ? load_val_i : (cnt_q - CNT_W'(1));
    pend_en = clr_i | (~load_i & count_i & at_end);
    pend_d  = ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;

  // R2: one step down per counting edge
  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4: no movement while counting is off
  assert_hold_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_i && !load_i) |=> $stable(cnt_q));
  // R7: zero is held and pending is raised
  assert_zero_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i && !load_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0 && pend_q));
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
  import irq_timer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_we_i,
  input  logic              ctrl_we_i,
  input  logic              ack_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              irq_o
);
  localparam int CNT_W = DATA_W + 1 + PRE_LOG2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic [DATA_W-1:0] latch;
  tmr_ctrl_t         ctrl;
  logic [CNT_W-1:0]  stop_val, ack_val, load_val, cnt;
  logic              load, count_on, pend;

  irq_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .latch_we_i(latch_we_i),
    .ctrl_we_i (ctrl_we_i),
    .wdata_i   (wdata_i),
    .latch_o   (latch),
    .ctrl_o    (ctrl)
  );

  irq_timer_reload #(.DATA_W(DATA_W), .PRE_LOG2(PRE_LOG2), .CNT_W(CNT_W)) u_reload (
    .latch_i   (latch),
    .stop_val_o(stop_val),
    .ack_val_o (ack_val)
  );

  always_comb begin
    load     = ack_we_i | (ctrl_we_i & ~wdata_i[RUN_BIT]);
    load_val = ack_we_i ? ack_val : stop_val;
    count_on = ctrl.run & ctrl.arm;
  end

  irq_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .load_i    (load),
    .load_val_i(load_val),
    .count_i   (count_on),
    .clr_i     (ack_we_i),
    .cnt_o     (cnt),
    .pend_o    (pend)
  );

  assign irq_o = pend & ctrl.irq_en;

  // R6: acknowledge drops the request
  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ack_we_i |=> !irq_o);
  // R3: stop write reloads and halts
  assert_stop_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ctrl_we_i && !wdata_i[RUN_BIT] && !ack_we_i) |=> (cnt == $past(stop_val) && !count_on));
  // R5: disabling the request line masks it
  assert_irq_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ctrl_we_i && !wdata_i[IRQEN_BIT]) |=> !irq_o);
endmodule

// File: tb/sim_irq_delay_timer.sv
`timescale 1ns/1ps
module sim_irq_delay_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       latch_we, ctrl_we, ack_we;
  logic [7:0] wdata;
  logic       irq;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_delay_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .latch_we_i(latch_we), .ctrl_we_i(ctrl_we),
    .ack_we_i(ack_we), .wdata_i(wdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(input int sel, input logic [7:0] d);
    wdata = d;
    latch_we = (sel == 0);
    ctrl_we  = (sel == 1);
    ack_we   = (sel == 2);
    @(posedge clk);
    @(negedge clk);
    latch_we = 1'b0; ctrl_we = 1'b0; ack_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(output int n);
    n = 0;
    while (!irq && n < 6000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int n;
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    wr(1, 8'h07);
    meas(n);
    chk(n == 1, "R1", "edges to irq from zero counter", n, 1);
  endtask

  task automatic t_ack(input logic [7:0] l, input int exp);
    int n;
    wr(0, l); wr(1, 8'h06); wr(1, 8'h07); wr(2, 8'h00);
    meas(n);
    chk(n == exp, "R2", $sformatf("ack delay L=%0d", l), n, exp);
  endtask

  task automatic t_ctrl(input logic [7:0] l, input int exp);
    int n;
    wr(0, l); wr(2, 8'h00); wr(1, 8'h06); wr(1, 8'h07);
    meas(n);
    chk(n == exp, "R3", $sformatf("stop-reload delay L=%0d", l), n, exp);
  endtask

  task automatic t_stop();
    int n;
    wr(0, 8'd3); wr(1, 8'h06); wr(1, 8'h07); wr(2, 8'h00);
    idle(10);
    wr(1, 8'h06);
    idle(200);
    chk(irq == 1'b0, "R3", "irq while stopped", int'(irq), 0);
    wr(1, 8'h07);
    meas(n);
    chk(n == 80, "R3", "delay after stop reload L=3", n, 80);
  endtask

  task automatic t_arm();
    int n;
    wr(0, 8'd0); wr(2, 8'h00); wr(1, 8'h02); wr(1, 8'h03);
    idle(100);
    chk(irq == 1'b0, "R4", "irq with arm clear", int'(irq), 0);
    wr(1, 8'h07);
    meas(n);
    chk(n == 17, "R4", "delay resumes from held count", n, 17);
  endtask

  task automatic t_mask();
    wr(0, 8'd0); wr(2, 8'h00); wr(1, 8'h05);
    idle(40);
    chk(irq == 1'b0, "R5", "irq masked while pending", int'(irq), 0);
    wr(1, 8'h07);
    chk(irq == 1'b1, "R5", "kept pending shows on enable", int'(irq), 1);
    wr(1, 8'h05);
    chk(irq == 1'b0, "R7", "irq low after enable cleared", int'(irq), 0);
    idle(5);
    wr(1, 8'h07);
    chk(irq == 1'b1, "R7", "irq again without ack", int'(irq), 1);
    wr(2, 8'h00);
    chk(irq == 1'b0, "R6", "irq low after ack", int'(irq), 0);
    idle(1);
    chk(irq == 1'b1, "R2", "L=0 ack reload of 1", int'(irq), 1);
  endtask

  task automatic t_latch_mid();
    int n;
    wr(0, 8'd10); wr(1, 8'h06); wr(1, 8'h07); wr(2, 8'h00);
    idle(20);
    wr(0, 8'd0);
    meas(n);
    chk(21 + n == 176, "R8", "delay unchanged by latch write", 21 + n, 176);
  endtask

  initial begin
    rst_n = 1'b0; latch_we = 1'b0; ctrl_we = 1'b0; ack_we = 1'b0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_ack(8'd0, 1);
    t_ack(8'd5, 96);
    t_ack(8'd255, 4096);
    t_ctrl(8'd0, 17);
    t_ctrl(8'd3, 80);
    t_ctrl(8'd255, 4112);
    t_stop();
    t_arm();
    t_mask();
    t_latch_mid();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule